// File: doc/BRIEF.md
# Ethernet Receive Frame Error Checker

This block watches a 64-bit packet stream that carries received Ethernet frames toward a client. It counts the bytes of every frame, tests the total against a fixed 64-byte minimum and a configurable maximum, and compares the length/type field with the number of bytes the frame actually carries. It also collects three one-bit indications from upstream: a PHY fault, a CRC mismatch and a receive-buffer overflow.

All of these results are merged into a 6-bit error vector. The vector is valid only on the last beat of a frame. It is driven combinationally in the same cycle as that beat, so the client sees it alongside end-of-packet. The stream itself is not touched. The block only observes beats that the client accepts, which are beats where valid and ready are both high.

Top module: `rx_frame_err_check`

## Requirements
- R1: `err_valid` is high only in a cycle where `rx_valid`, `rx_ready` and `rx_eop` are all high, and `err_vec` is all zero in every other cycle, including just after reset.
- R2: A cycle without acceptance (valid low or ready low) adds no bytes and no flags to the frame, even if it shows end-of-packet or raised error flags.
- R3: Bit 2 of `err_vec` is set when the frame total is below 64 bytes. The total is 8 bytes for each accepted beat before the last one, plus 8 minus `rx_empty` for the last beat.
- R4: Bit 3 is set when the frame total exceeds `MAX_FRAME` (default 1518). The internal count saturates, so longer frames still report bit 3.
- R5: The byte at frame offset k sits in lane k mod 8 of its beat, and lane 0 is `rx_data[63:56]`. The length/type field is frame bytes 12 (high) and 13 (low). When that field is present and at most 1500, bit 4 is set unless the total equals the field plus 18, or unless the field is below 46 and the total is exactly 64 (a padded frame).
- R6: A length/type value above 1500 is treated as a type code and never sets bit 4. A frame shorter than 14 bytes has no field and never sets bit 4.
- R7: `phy_err_in`, `crc_err_in` and `ovf_err_in` are sampled on every accepted beat of a frame. Any one raised once sets bit 0, bit 1 or bit 5 respectively on that frame's end-of-packet beat.
- R8: An accepted start-of-packet beat discards all state left from earlier frames, including a frame that never ended.
- R9: A single-beat frame, with start and end on the same beat, is checked by the same rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Beat qualifier |
| rx_ready | input | 1 | Client accepts the beat |
| rx_sop | input | 1 | First beat of a frame |
| rx_eop | input | 1 | Last beat of a frame |
| rx_data | input | 64 | Frame bytes, lane 0 in the top byte |
| rx_empty | input | 3 | Unused bytes in the last beat |
| phy_err_in | input | 1 | PHY fault indication |
| crc_err_in | input | 1 | CRC mismatch indication |
| ovf_err_in | input | 1 | Receive buffer overflow indication |
| err_vec | output | 6 | Error vector: 0 PHY, 1 CRC, 2 undersize, 3 oversize, 4 length, 5 overflow |
| err_valid | output | 1 | Error vector qualifier on the accepted last beat |

## Verification
The assertions assume that frames are well formed at the stream level. Each frame opens with an accepted start-of-packet beat and closes with one end-of-packet beat. The bytes 12 and 13 of the field share one beat. The empty count is zero except on the last beat. The scoreboard driver builds every frame from a byte length, which fixes the beat count and empty value, so the stimulus always stays within these assumptions. The only deliberate departures are non-accepted beats carrying end-of-packet or flags, and a frame abandoned without an end. The rules still define the expected result for both.

// File: rtl/rx_chk_pkg.sv
package rx_chk_pkg;
  localparam int ERR_W     = 6;
  localparam int ERR_PHY   = 0;
  localparam int ERR_CRC   = 1;
  localparam int ERR_UNDER = 2;
  localparam int ERR_OVER  = 3;
  localparam int ERR_LEN   = 4;
  localparam int ERR_OVF   = 5;

  typedef struct packed {
    logic ovf;
    logic crc;
    logic phy;
  } rx_flags_t;
endpackage

// File: rtl/rx_byte_tally.sv
module rx_byte_tally #(
  parameter int BYTES   = 8,
  parameter int EMPTY_W = 3,
  parameter int CNT_W   = 12,
  parameter int SAT     = 1519
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_ok,
  input  logic               sop,
  input  logic [EMPTY_W-1:0] empty,
  output logic [CNT_W-1:0]   total,
  output logic [1:0]         idx_base
);
  logic [CNT_W-1:0] cnt_q, cnt_d, base, step;
  logic [1:0]       idx_q, idx_d;

  always_comb begin
    base     = sop ? '0 : cnt_q;
    idx_base = sop ? 2'd0 : idx_q;
    total    = base + CNT_W'(BYTES) - CNT_W'(empty);
    step     = base + CNT_W'(BYTES);
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    if (beat_ok) begin
      cnt_d = (step > CNT_W'(SAT)) ? CNT_W'(SAT) : step;
      idx_d = (idx_base == 2'd3) ? 2'd3 : idx_base + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  // R2: idle cycles leave the tally untouched
  p_tally_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_ok |=> $stable(cnt_q));
  // R8: an accepted start beat restarts the count at one full beat
  p_tally_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && sop) |=> (cnt_q == CNT_W'(BYTES)));
endmodule

// File: rtl/rx_lentype_grab.sv
module rx_lentype_grab #(
  parameter int DATA_W  = 64,
  parameter int BYTES   = 8,
  parameter int EMPTY_W = 3,
  parameter int LEN_OFS = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_ok,
  input  logic               sop,
  input  logic               eop,
  input  logic [1:0]         idx_base,
  input  logic [EMPTY_W-1:0] empty,
  input  logic [DATA_W-1:0]  data,
  output logic               lf_seen,
  output logic [15:0]        lf_val
);
  localparam int BEAT     = LEN_OFS / BYTES;
  localparam int LANE     = LEN_OFS % BYTES;
  localparam int TOP_BIT  = DATA_W - 1 - 8 * LANE;
  localparam int MAX_EMPT = BYTES - LANE - 2;

  logic        hit, seen_q, seen_d;
  logic [15:0] val_q, val_d, field;

  always_comb begin
    field  = data[TOP_BIT -: 16];
    hit    = beat_ok && (idx_base == 2'(BEAT)) &&
             (!eop || (32'(empty) <= 32'(MAX_EMPT)));
    seen_d = seen_q;
    val_d  = val_q;
    if (beat_ok && sop) seen_d = 1'b0;
    if (hit) begin
      seen_d = 1'b1;
      val_d  = field;
    end
    lf_seen = hit || (seen_q && !(beat_ok && sop));
    lf_val  = hit ? field : val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      val_q  <= '0;
    end else begin
      seen_q <= seen_d;
      val_q  <= val_d;
    end
  end

  // R2: the captured field does not change on a stalled cycle
  p_field_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_ok |=> ($stable(seen_q) && $stable(val_q)));
endmodule

// File: rtl/rx_flag_hold.sv
module rx_flag_hold
  import rx_chk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      beat_ok,
  input  logic      sop,
  input  rx_flags_t flags_in,
  output rx_flags_t flags_out
);
  rx_flags_t hold_q, hold_d, base;

  always_comb begin
    base      = (beat_ok && sop) ? rx_flags_t'('0) : hold_q;
    flags_out = beat_ok ? (base | flags_in) : hold_q;
    hold_d    = flags_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  // R2: flags raised on a non-accepted cycle are not collected
  p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_ok |=> $stable(hold_q));
  // R7: a flag collected mid-frame stays set until the next start
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && !sop && hold_q.phy) |=> hold_q.phy);
endmodule

// File: rtl/rx_frame_err_check.sv
module rx_frame_err_check
  import rx_chk_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  parameter int LEN_MAX   = 1500,
  parameter int LEN_OFS   = 12,
  parameter int HDR_FCS   = 18,
  parameter int EMPTY_W   = $clog2(DATA_W / 8)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic               rx_ready,
  input  logic               rx_sop,
  input  logic               rx_eop,
  input  logic [DATA_W-1:0]  rx_data,
  input  logic [EMPTY_W-1:0] rx_empty,
  input  logic               phy_err_in,
  input  logic               crc_err_in,
  input  logic               ovf_err_in,
  output logic [ERR_W-1:0]   err_vec,
  output logic               err_valid
);
  localparam int BYTES   = DATA_W / 8;
  localparam int SAT     = MAX_FRAME + 1;
  localparam int CNT_W   = $clog2(SAT + 2 * BYTES + 1);
  localparam int MIN_PAY = MIN_FRAME - HDR_FCS;

  logic [1:0]       rst_sync;
  logic             rst_n_int;
  logic             beat_ok, fin;
  logic [CNT_W-1:0] total;
  logic [1:0]       idx_base;
  logic             lf_seen, lf_chk, lf_ok;
  logic [15:0]      lf_val;
  rx_flags_t        flags_in, flags_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  assign beat_ok  = rx_valid && rx_ready;
  assign flags_in = '{ovf: ovf_err_in, crc: crc_err_in, phy: phy_err_in};

  rx_byte_tally #(.BYTES(BYTES), .EMPTY_W(EMPTY_W), .CNT_W(CNT_W), .SAT(SAT)) u_tally (
    .clk(clk), .rst_n(rst_n_int), .beat_ok(beat_ok), .sop(rx_sop),
    .empty(rx_empty), .total(total), .idx_base(idx_base));

  rx_lentype_grab #(.DATA_W(DATA_W), .BYTES(BYTES), .EMPTY_W(EMPTY_W), .LEN_OFS(LEN_OFS)) u_len (
    .clk(clk), .rst_n(rst_n_int), .beat_ok(beat_ok), .sop(rx_sop), .eop(rx_eop),
    .idx_base(idx_base), .empty(rx_empty), .data(rx_data),
    .lf_seen(lf_seen), .lf_val(lf_val));

  rx_flag_hold u_flags (
    .clk(clk), .rst_n(rst_n_int), .beat_ok(beat_ok), .sop(rx_sop),
    .flags_in(flags_in), .flags_out(flags_now));

  always_comb begin
    fin    = beat_ok && rx_eop;
    lf_chk = lf_seen && (32'(lf_val) <= 32'(LEN_MAX));
    lf_ok  = (32'(total) == 32'(lf_val) + 32'(HDR_FCS)) ||
             ((32'(lf_val) < 32'(MIN_PAY)) && (32'(total) == 32'(MIN_FRAME)));
    err_vec = '0;
    if (fin) begin
      err_vec[ERR_PHY]   = flags_now.phy;
      err_vec[ERR_CRC]   = flags_now.crc;
      err_vec[ERR_UNDER] = 32'(total) < 32'(MIN_FRAME);
      err_vec[ERR_OVER]  = 32'(total) > 32'(MAX_FRAME);
      err_vec[ERR_LEN]   = lf_chk && !lf_ok;
      err_vec[ERR_OVF]   = flags_now.ovf;
    end
    err_valid = fin;
  end

  // R1: outside an accepted last beat the vector stays clear
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    !err_valid |-> (err_vec == '0));
  // R3: undersize and oversize never report together
  p_size_excl_r3: assert property (@(posedge clk) disable iff (!rst_n_int)
    err_valid |-> !(err_vec[ERR_UNDER] && err_vec[ERR_OVER]));
endmodule

// File: tb/rx_frame_err_check_tb.sv
module rx_frame_err_check_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_ready, rx_sop, rx_eop;
  logic [63:0] rx_data;
  logic [2:0]  rx_empty;
  logic        phy_err_in, crc_err_in, ovf_err_in;
  logic [5:0]  err_vec;
  logic        err_valid;

  int checks = 0;
  int failures = 0;
  bit mon_on = 1'b0;
  logic [5:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  rx_frame_err_check u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data), .rx_empty(rx_empty),
    .phy_err_in(phy_err_in), .crc_err_in(crc_err_in), .ovf_err_in(ovf_err_in),
    .err_vec(err_vec), .err_valid(err_valid));

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rx_valid = 0; rx_ready = 1; rx_sop = 0; rx_eop = 0; rx_data = '0;
    rx_empty = 0; phy_err_in = 0; crc_err_in = 0; ovf_err_in = 0;
  endtask

  function automatic logic [7:0] fbyte(int k, int n, int lf);
    if (k >= n) return 8'h00;
    if (k == 12) return lf[15:8];
    if (k == 13) return lf[7:0];
    return k[7:0] ^ 8'hA5;
  endfunction

  // n bytes, length/type lf, flag raised on beat index (-1 none)
  task automatic send_frame(input string tag, input int n, input int lf,
                            input int phy_b, input int crc_b, input int ovf_b,
                            input bit stall, input bit no_end);
    int beats = (n + 7) / 8;
    logic [5:0] e = '0;
    e[0] = (phy_b >= 0) && (phy_b < beats);
    e[1] = (crc_b >= 0) && (crc_b < beats);
    e[2] = n < 64;
    e[3] = n > 1518;
    e[4] = (n >= 14) && (lf <= 1500) && !((n == lf + 18) || (lf < 46 && n == 64));
    e[5] = (ovf_b >= 0) && (ovf_b < beats);
    if (!no_end) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    for (int b = 0; b < beats; b++) begin
      if (no_end && b == beats - 1) break;
      if (stall && b == beats - 1) begin
        @(posedge clk); #1;
        rx_valid = 1; rx_ready = 0; rx_sop = 0; rx_eop = 1;
        phy_err_in = 1; crc_err_in = 1; ovf_err_in = 1;
        @(posedge clk); #1;
        rx_valid = 0; rx_ready = 1; rx_eop = 1;
      end
      @(posedge clk); #1;
      rx_valid = 1; rx_ready = 1;
      rx_sop = (b == 0);
      rx_eop = (b == beats - 1);
      rx_empty = (b == beats - 1) ? 3'(beats * 8 - n) : 3'd0;
      for (int l = 0; l < 8; l++) rx_data[63 - 8*l -: 8] = fbyte(8*b + l, n, lf);
      phy_err_in = (b == phy_b);
      crc_err_in = (b == crc_b);
      ovf_err_in = (b == ovf_b);
    end
    @(posedge clk); #1;
    idle();
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (err_valid) begin
        if (exp_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R1 unexpected err_valid actual=%h expected=none", err_vec);
        end else begin
          chk(tag_q.pop_front(), {1'b1, err_vec}, {1'b1, exp_q.pop_front()});
        end
      end else begin
        chk("R1 quiet vector", {1'b0, err_vec}, 7'h00);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset state", {err_valid, err_vec}, 7'h00);
    mon_on = 1;
    send_frame("R3 exact minimum", 64, 46, -1, -1, -1, 0, 0);
    send_frame("R3 undersize 60", 60, 16'h0800, -1, -1, -1, 0, 0);
    send_frame("R4 exact maximum", 1518, 1500, -1, -1, -1, 0, 0);
    send_frame("R4 oversize 1519", 1519, 16'h0800, -1, -1, -1, 0, 0);
    send_frame("R4 oversize saturating", 2000, 16'h86DD, -1, -1, -1, 0, 0);
    send_frame("R5 length mismatch", 100, 50, -1, -1, -1, 0, 0);
    send_frame("R5 length match", 100, 82, -1, -1, -1, 0, 0);
    send_frame("R5 padded short payload", 64, 10, -1, -1, -1, 0, 0);
    send_frame("R5 field at limit mismatch", 100, 1500, -1, -1, -1, 0, 0);
    send_frame("R6 type code", 100, 1501, -1, -1, -1, 0, 0);
    send_frame("R7 phy crc ovf flags", 200, 182, 0, 24, 10, 0, 0);
    send_frame("R2 stalled flags ignored", 72, 54, -1, -1, -1, 1, 0);
    send_frame("R8 abandoned", 80, 50, 1, 2, 3, 0, 1);
    send_frame("R8 clean after abandon", 80, 62, -1, -1, -1, 0, 0);
    send_frame("R9 single beat", 8, 0, -1, -1, -1, 0, 0);
    send_frame("R9 single beat empty 3", 5, 0, 0, -1, -1, 1, 0);
    send_frame("R5 field in last beat", 14, 0, -1, -1, -1, 0, 0);
    send_frame("R6 no field 13 bytes", 13, 0, -1, -1, -1, 0, 0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 all frames reported", {1'b0, 6'(exp_q.size())}, 7'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule